// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Periodic Interrupt Taps

This block keeps a 12-bit count that runs without pause on a one-cycle tick enable arriving once per microsecond. Nothing loads, stops or compares it: firmware times an event by sampling the count at its start and its end and subtracting the two samples.

Two periodic interrupt requests come from fixed bits of the same count. The fast request recurs every 128 ticks (128 µs) and the slow request every 1024 ticks (1.024 ms). Each request is a one-cycle pulse that also sets a pending flag. The flag stays set until firmware acknowledges it.

The count is read as two bytes. Reading the low byte latches the upper nibble in a small read state machine. A following high-byte read therefore returns a value that matches the low byte, even if the count carried between the two reads.

Top module: `ftm_timer`

## Requirements
- R1: After reset the count is 0, both pending flags are 0, both pulses are low, `lo_byte_o` and `hi_byte_o` read 0, and the read machine is in state RD_LIVE.
- R2: The count rises by exactly one on each clock edge that samples `tick_i` high. It holds its value on every other edge.
- R3: The count wraps from 0xFFF to 0x000. It has no overflow flag, and the wrap produces no output beyond the tap pulses that R4 and R5 define for a count of 0.
- R4: `irq_fast_o` is high for exactly one clock cycle, the cycle in which the count has just become a multiple of 128 (bit 6 fell from 1 to 0). It is low in every other cycle.
- R5: `irq_slow_o` is high for exactly one clock cycle, the cycle in which the count has just become a multiple of 1024 (bit 9 fell from 1 to 0). It is low in every other cycle.
- R6: Each pulse sets its pending flag on the next clock edge. The flag holds until its acknowledge input is sampled high, and it reads 0 from the cycle after that edge.
- R7: If an acknowledge is sampled on the same edge as its own pulse, the pulse wins and the pending flag stays 1.
- R8: On an edge where `rd_lo_i` is high, the count's upper nibble is captured and the machine moves to RD_HELD, from RD_LIVE or from RD_HELD. In RD_HELD, `hi_byte_o[3:0]` shows the captured nibble. It does so even after further ticks.
- R9: `hi_byte_o[7:4]` is always 0, and `lo_byte_o` always shows the live low 8 bits of the count.
- R10: On an edge where `rd_hi_i` is high and `rd_lo_i` is low, RD_HELD returns to RD_LIVE. In RD_LIVE, `hi_byte_o[3:0]` shows the live upper nibble. If both strobes are high on the same edge, the low-byte read wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable, once per microsecond |
| rd_lo_i | input | 1 | Low-byte read strobe; latches the upper nibble |
| rd_hi_i | input | 1 | High-byte read strobe; releases the latched nibble |
| ack_fast_i | input | 1 | Clears the 128-tick pending flag |
| ack_slow_i | input | 1 | Clears the 1024-tick pending flag |
| lo_byte_o | output | 8 | Low byte of the count |
| hi_byte_o | output | 8 | Upper nibble (latched or live), zero-extended |
| irq_fast_o | output | 1 | 128-tick request pulse |
| irq_slow_o | output | 1 | 1024-tick request pulse |
| pend_fast_o | output | 1 | 128-tick pending flag |
| pend_slow_o | output | 1 | 1024-tick pending flag |

## Verification
The bench runs the count with sparse ticks and with back-to-back ticks, and through the wrap from 0xFFF. A design that tapped the wrong bit, or that fired on a rising edge, would pulse at the wrong counts or at twice the rate. A design that missed the wrap would lose the pulses at count 0.

An acknowledge is placed on the same cycle as a pulse. A design with clear-over-set priority would drop the pending request.

A low-byte read is placed on the tick that carries from 0x0FF to 0x100. A design that did not latch the nibble would return a high byte of 1 with a low byte of 0xFF. A design that never released the latch would show a stale high byte after the high-byte read.

// File: rtl/ftm_pkg.sv
package ftm_pkg;
    typedef enum logic {
        RD_LIVE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/ftm_counter.sv
module ftm_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (tick_i) begin
            cnt_o <= cnt_o + 1'b1;   // natural wrap, no flag
        end
    end
endmodule

// File: rtl/ftm_tap.sv
module ftm_tap (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_i,
    input  logic ack_i,
    output logic pulse_o,
    output logic pend_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= tap_i;
        end
    end

    // falling edge of the tapped bit
    assign pulse_o = prev_q & ~tap_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else if (pulse_o) begin
            pend_o <= 1'b1;          // set beats acknowledge
        end else if (ack_i) begin
            pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/ftm_read.sv
module ftm_read
    import ftm_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    output logic [BYTE_W-1:0] lo_byte_o,
    output logic [BYTE_W-1:0] hi_byte_o
);
    localparam int HI_W  = CNT_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;

    rd_state_e       state_q, state_d;
    logic [HI_W-1:0] hold_q;
    logic [HI_W-1:0] nib;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_LIVE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_lo_i) begin
                hold_q <= cnt_i[CNT_W-1:BYTE_W];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_LIVE: if (rd_lo_i) state_d = RD_HELD;
            RD_HELD: begin
                if (rd_lo_i)      state_d = RD_HELD;
                else if (rd_hi_i) state_d = RD_LIVE;
            end
            default: state_d = RD_LIVE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RD_HELD: nib = hold_q;
            default: nib = cnt_i[CNT_W-1:BYTE_W];
        endcase
        lo_byte_o = cnt_i[BYTE_W-1:0];
        hi_byte_o = {{PAD_W{1'b0}}, nib};
    end
endmodule

// File: rtl/ftm_timer.sv
module ftm_timer #(
    parameter int CNT_W     = 12,
    parameter int BYTE_W    = 8,
    parameter int FAST_LOG2 = 7,
    parameter int SLOW_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    input  logic              ack_fast_i,
    input  logic              ack_slow_i,
    output logic [BYTE_W-1:0] lo_byte_o,
    output logic [BYTE_W-1:0] hi_byte_o,
    output logic              irq_fast_o,
    output logic              irq_slow_o,
    output logic              pend_fast_o,
    output logic              pend_slow_o
);
    localparam int N_TAP = 2;

    logic [CNT_W-1:0] cnt_q;
    logic [N_TAP-1:0] ack_v, pulse_v, pend_v;

    assign ack_v = {ack_slow_i, ack_fast_i};

    ftm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .cnt_o  (cnt_q)
    );

    for (genvar g = 0; g < N_TAP; g++) begin : g_tap
        localparam int TBIT = (g == 0) ? FAST_LOG2 - 1 : SLOW_LOG2 - 1;
        ftm_tap u_tap (
            .clk     (clk),
            .rst_n   (rst_n),
            .tap_i   (cnt_q[TBIT]),
            .ack_i   (ack_v[g]),
            .pulse_o (pulse_v[g]),
            .pend_o  (pend_v[g])
        );
    end

    assign irq_fast_o  = pulse_v[0];
    assign irq_slow_o  = pulse_v[1];
    assign pend_fast_o = pend_v[0];
    assign pend_slow_o = pend_v[1];

    ftm_read #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt_q),
        .rd_lo_i   (rd_lo_i),
        .rd_hi_i   (rd_hi_i),
        .lo_byte_o (lo_byte_o),
        .hi_byte_o (hi_byte_o)
    );
endmodule

// File: rtl/ftm_timer_chk.sv
module ftm_timer_chk #(
    parameter int CNT_W     = 12,
    parameter int BYTE_W    = 8,
    parameter int FAST_LOG2 = 7,
    parameter int SLOW_LOG2 = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              ack_fast_i,
    input logic              irq_fast_o,
    input logic              irq_slow_o,
    input logic              pend_fast_o,
    input logic [BYTE_W-1:0] hi_byte_o,
    input logic [CNT_W-1:0]  cnt
);
    localparam int HI_W = CNT_W - BYTE_W;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt)); // R2
    AST_FAST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o |-> cnt[FAST_LOG2-1:0] == '0); // R4
    AST_FAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o |=> !irq_fast_o); // R4
    AST_SLOW_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_slow_o |-> cnt[SLOW_LOG2-1:0] == '0); // R5
    AST_SLOW_WITH_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_slow_o |-> irq_fast_o); // R5
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_fast_o && !ack_fast_i) |=> pend_fast_o); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o |=> pend_fast_o); // R7
    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hi_byte_o[BYTE_W-1:HI_W] == '0); // R9
endmodule

bind ftm_timer ftm_timer_chk #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .ack_fast_i  (ack_fast_i),
    .irq_fast_o  (irq_fast_o),
    .irq_slow_o  (irq_slow_o),
    .pend_fast_o (pend_fast_o),
    .hi_byte_o   (hi_byte_o),
    .cnt         (cnt_q)
);

// File: tb/test_ftm_timer.sv
module test_ftm_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0, rd_lo_i = 1'b0, rd_hi_i = 1'b0;
    logic ack_fast_i = 1'b0, ack_slow_i = 1'b0;
    logic [7:0] lo_byte_o, hi_byte_o;
    logic irq_fast_o, irq_slow_o, pend_fast_o, pend_slow_o;

    int n_chk = 0;
    int n_fail = 0;
    int model = 0;
    bit exp_pf = 0, exp_ps = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ftm_timer i_ftm_timer (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(irq_fast_o == 1'b0, req, "fast pulse idle", irq_fast_o, 0);
        chk(irq_slow_o == 1'b0, req, "slow pulse idle", irq_slow_o, 0);
        chk(lo_byte_o == model[7:0], "R2", "low byte held", lo_byte_o, model[7:0]);
        chk(pend_fast_o == exp_pf, "R6", "fast pending", pend_fast_o, exp_pf);
        chk(pend_slow_o == exp_ps, "R6", "slow pending", pend_slow_o, exp_ps);
    endtask

    // one tick then gap idle cycles; read machine assumed RD_LIVE
    task automatic do_tick(input int gap);
        tick_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_i = 1'b0;
        model = (model + 1) % 4096;
        chk(lo_byte_o == model[7:0], "R2", "low byte", lo_byte_o, model[7:0]);
        chk(hi_byte_o == {4'h0, model[11:8]}, "R10", "live high byte", hi_byte_o, model[11:8]);
        chk(pend_fast_o == exp_pf, "R6", "fast pending", pend_fast_o, exp_pf);
        chk(pend_slow_o == exp_ps, "R6", "slow pending", pend_slow_o, exp_ps);
        chk(irq_fast_o == (model % 128 == 0), "R4", "fast pulse", irq_fast_o, model % 128 == 0);
        chk(irq_slow_o == (model % 1024 == 0), "R5", "slow pulse", irq_slow_o, model % 1024 == 0);
        if (model % 128 == 0) exp_pf = 1'b1;
        if (model % 1024 == 0) exp_ps = 1'b1;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            chk_idle("R4");
        end
    endtask

    task automatic do_ack(input bit f, input bit s);
        ack_fast_i = f;
        ack_slow_i = s;
        @(posedge clk);
        @(negedge clk);
        ack_fast_i = 1'b0;
        ack_slow_i = 1'b0;
        if (f) exp_pf = 1'b0;
        if (s) exp_ps = 1'b0;
        chk(pend_fast_o == exp_pf, "R6", "fast pending after ack", pend_fast_o, exp_pf);
        chk(pend_slow_o == exp_ps, "R6", "slow pending after ack", pend_slow_o, exp_ps);
    endtask

    task automatic t_reset;
        chk(lo_byte_o == 8'h00, "R1", "reset low byte", lo_byte_o, 0);
        chk(hi_byte_o == 8'h00, "R1", "reset high byte", hi_byte_o, 0);
        chk(pend_fast_o == 1'b0 && pend_slow_o == 1'b0, "R1", "reset pending",
            {pend_slow_o, pend_fast_o}, 0);
        chk(irq_fast_o == 1'b0 && irq_slow_o == 1'b0, "R1", "reset pulses",
            {irq_slow_o, irq_fast_o}, 0);
    endtask

    task automatic t_sparse;   // R2 R4 with idle gaps
        for (int i = 0; i < 300; i++) do_tick(2);
        do_ack(1'b1, 1'b1);
    endtask

    task automatic t_wrap;     // R3 R5 dense run across 0xFFF
        while (model != 4095) do_tick(0);
        do_ack(1'b1, 1'b1);
        do_tick(1);
        chk(lo_byte_o == 8'h00 && hi_byte_o == 8'h00, "R3", "wrap to zero",
            {hi_byte_o, lo_byte_o}, 0);
        chk(pend_fast_o && pend_slow_o, "R3", "wrap raised both taps",
            {pend_slow_o, pend_fast_o}, 3);
        do_ack(1'b1, 1'b0);
        chk(pend_slow_o == 1'b1, "R6", "slow pending kept", pend_slow_o, 1);
        do_ack(1'b0, 1'b1);
    endtask

    task automatic t_collide;  // R7 ack in the pulse cycle
        while (model % 128 != 127) do_tick(0);
        tick_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_i = 1'b0;
        model = (model + 1) % 4096;
        chk(irq_fast_o == 1'b1, "R4", "pulse before collision", irq_fast_o, 1);
        ack_fast_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_fast_i = 1'b0;
        exp_pf = 1'b1;
        chk(pend_fast_o == 1'b1, "R7", "set wins over ack", pend_fast_o, 1);
        if (model % 1024 == 0) exp_ps = 1'b1;
        do_ack(1'b1, 1'b1);
    endtask

    task automatic t_read;     // R8 R10 coherent split read across a carry
        while (model[7:0] != 8'hFF) do_tick(0);
        chk(lo_byte_o == 8'hFF, "R9", "low byte before carry", lo_byte_o, 8'hFF);
        rd_lo_i = 1'b1;
        tick_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_lo_i = 1'b0;
        tick_i = 1'b0;
        chk(hi_byte_o == {4'h0, model[11:8]}, "R8", "held nibble",
            hi_byte_o, model[11:8]);
        model = (model + 1) % 4096;
        if (model % 128 == 0) exp_pf = 1'b1;
        if (model % 1024 == 0) exp_ps = 1'b1;
        @(negedge clk);
        chk(hi_byte_o[7:4] == 4'h0, "R9", "pad bits", hi_byte_o[7:4], 0);
        chk(hi_byte_o[3:0] != model[11:8], "R8", "latched not live",
            hi_byte_o[3:0], (model[11:8] + 15) % 16);
        rd_hi_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_hi_i = 1'b0;
        chk(hi_byte_o == {4'h0, model[11:8]}, "R10", "released to live",
            hi_byte_o, model[11:8]);
        // both strobes together: low-byte read wins
        rd_lo_i = 1'b1;
        rd_hi_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_lo_i = 1'b0;
        rd_hi_i = 1'b0;
        for (int i = 0; i < 256; i++) begin
            tick_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick_i = 1'b0;
        end
        chk(hi_byte_o[3:0] != ((model + 256) / 256) % 16, "R10", "low read wins",
            hi_byte_o[3:0], model[11:8]);
        chk(hi_byte_o == {4'h0, model[11:8]}, "R8", "nibble still held",
            hi_byte_o, model[11:8]);
        model = (model + 256) % 4096;
        rd_hi_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_hi_i = 1'b0;
        chk(hi_byte_o == {4'h0, model[11:8]}, "R10", "live after release",
            hi_byte_o, model[11:8]);
        chk(lo_byte_o == model[7:0], "R9", "live low byte", lo_byte_o, model[7:0]);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sparse();
        t_wrap();
        t_collide();
        t_read();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule